// File: doc/BRIEF.md
# Oversampled Serial Receiver with Four-Character Buffer

This block is the receive half of an asynchronous serial port. A two-flop synchronizer brings the line into the clock domain. A deframer, stepped by an oversampling tick at sixteen ticks per bit, turns 8N1 frames (one start bit, eight data bits with the LSB first, one stop bit) into characters. It takes three samples around the middle of each bit and keeps the majority value. A start bit counts only if its mid-bit vote is low.

Each completed character is stored in a four-entry first-in first-out buffer, together with a flag that marks a bad stop bit. Software reads the oldest character from the read port and removes it with a one-cycle pop strobe. A one-cycle interrupt pulse tells software that it has something to collect. A two-bit select sets when the pulse fires: on every character, when the buffer reaches three entries, or when it reaches four. If a character completes while all four entries are occupied, that character is lost and a sticky overrun flag is raised. The receiver then accepts no new frame until software clears the flag.

Top module: `rx_char_buffer`

## Requirements
- R1: While reset is asserted and right after it is released: `data_avail`=0, `rx_idle`=1, `overrun`=0 and `irq`=0.
- R2: A frame of one low start bit, eight data bits sent LSB first and a stop bit (16 ticks per bit) appears on `rd_data` once the frame completes, and `data_avail` goes to 1.
- R3: Up to four characters are held and read out in arrival order. A `rd_en` pulse removes the head entry.
- R4: With `irq_sel` = 2'b00 or 2'b01, `irq` pulses high for exactly one cycle for every character that enters the buffer.
- R5: With `irq_sel` = 2'b10, `irq` pulses only when an entry brings the buffer to exactly three characters.
- R6: With `irq_sel` = 2'b11, `irq` pulses only when an entry brings the buffer to four characters.
- R7: `rx_idle` is 0 while a frame is being assembled and returns to 1 after the stop bit.
- R8: A stop bit that votes 0 marks the character with a framing error. `rd_ferr` shows the mark of the head character and follows the character through the buffer.
- R9: A frame that completes while four characters are held and no pop occurs is discarded. It sets `overrun`, which stays 1 until a cycle with `ovf_clr`=1. While `overrun` is 1, no new frame is started (`rx_idle` stays 1).
- R10: A low pulse on the line whose mid-bit vote is high is rejected as a false start, and no character is stored.
- R11: When a frame completes in the same cycle as a pop on a full buffer, the new character is accepted and no overrun is raised.
- R12: A pop while the buffer is empty has no effect.
- R13: A one-tick glitch at the centre sample of a bit does not change the received bit, because of the three-sample majority vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Serial line, idle high |
| irq_sel | input | 2 | Interrupt threshold select |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | 8 | Head character |
| rd_ferr | output | 1 | Framing-error mark of the head character |
| ovf_clr | input | 1 | Clears the overrun flag |
| data_avail | output | 1 | Buffer holds at least one character |
| rx_idle | output | 1 | No frame in progress |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The two functions that can meet in one cycle are the buffer's write, when a frame completes, and its pop, when software reads. This matters on a full buffer: there, the order in which the two are resolved decides whether the new character is stored or an overrun is raised. The bench first measures how many cycles pass from the start edge of a frame to the write. It then fills the buffer, sends a fifth frame, and raises `rd_en` for exactly the cycle of the write. The result passes if `overrun` stays 0 and the four characters that follow come out as the second through fifth frames.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  parameter int unsigned RXB_DW = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxb_state_e;

  typedef struct packed {
    logic              ferr;
    logic [RXB_DW-1:0] data;
  } rxb_char_t;

endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb st_d = d;
    end else begin : g_chain
      always_comb st_d = {st_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/rxb_deframer.sv
module rxb_deframer
  import rxb_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx_s,
  input  logic      hold,
  output logic      done,
  output rxb_char_t chr,
  output logic      idle
);

  localparam int unsigned DW    = RXB_DW;
  localparam int unsigned CW    = $clog2(OSR);
  localparam int unsigned IW    = $clog2(DW);
  localparam int unsigned SMP_A = OSR / 2 - 1;
  localparam int unsigned SMP_B = OSR / 2;
  localparam int unsigned SMP_C = OSR / 2 + 1;

  rxb_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [1:0]    vote_q, vote_d;
  logic          ferr_q, ferr_d;
  logic          done_q, done_d;
  logic          maj;

  assign maj = (vote_q[0] & vote_q[1]) | (vote_q[0] & rx_s) | (vote_q[1] & rx_s);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    vote_d = vote_q;
    ferr_d = ferr_q;
    done_d = 1'b0;
    if (tick) begin
      if (st_q == ST_IDLE) begin
        if (!hold && !rx_s) begin
          st_d  = ST_START;
          cnt_d = CW'(1);
          idx_d = '0;
        end
      end else begin
        cnt_d = (cnt_q == CW'(OSR - 1)) ? '0 : cnt_q + CW'(1);
        if (cnt_q == CW'(SMP_A)) vote_d[0] = rx_s;
        if (cnt_q == CW'(SMP_B)) vote_d[1] = rx_s;
        if (cnt_q == CW'(SMP_C)) begin
          case (st_q)
            ST_START: begin
              if (maj) begin
                st_d  = ST_IDLE;
                cnt_d = '0;
              end
            end
            ST_DATA: sh_d = {maj, sh_q[DW-1:1]};
            ST_STOP: begin
              done_d = 1'b1;
              ferr_d = !maj;
              st_d   = ST_IDLE;
              cnt_d  = '0;
            end
            default: ;
          endcase
        end
        if (cnt_q == CW'(OSR - 1)) begin
          if (st_q == ST_START) begin
            st_d = ST_DATA;
          end else if (st_q == ST_DATA) begin
            if (idx_q == IW'(DW - 1)) st_d = ST_STOP;
            else                      idx_d = idx_q + IW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      vote_q <= 2'b11;
      ferr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      vote_q <= vote_d;
      ferr_q <= ferr_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign chr.ferr = ferr_q;
  assign chr.data = sh_q;
  assign idle     = (st_q == ST_IDLE);

endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [FW-1:0] fill,
  output logic [FW-1:0] fill_nxt,
  output logic          push_ok,
  output logic          drop
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          pop_ok;
  logic          full;

  assign full    = (cnt_q == FW'(DEPTH));
  assign pop_ok  = pop && (cnt_q != '0);
  assign push_ok = push && (!full || pop_ok);
  assign drop    = push && !push_ok;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (pop_ok)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + FW'(1);
      2'b01:   cnt_d = cnt_q - FW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= wdata;
  end

  assign rdata    = mem_q[rd_q];
  assign fill     = cnt_q;
  assign fill_nxt = cnt_d;

endmodule

// File: rtl/rxb_status.sv
module rxb_status #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          drop,
  input  logic [FW-1:0] fill_nxt,
  input  logic [1:0]    sel,
  input  logic          clr,
  output logic          overrun,
  output logic          irq
);

  localparam logic [FW-1:0] LVL_3Q   = FW'((DEPTH * 3) / 4);
  localparam logic [FW-1:0] LVL_FULL = FW'(DEPTH);

  logic ovr_q, ovr_d;
  logic irq_q, irq_d;
  logic hit;

  always_comb begin
    case (sel)
      2'b10:   hit = (fill_nxt == LVL_3Q);
      2'b11:   hit = (fill_nxt == LVL_FULL);
      default: hit = 1'b1;
    endcase
    irq_d = push_ok && hit;
    if (drop)     ovr_d = 1'b1;
    else if (clr) ovr_d = 1'b0;
    else          ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      irq_q <= irq_d;
    end
  end

  assign overrun = ovr_q;
  assign irq     = irq_q;

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxb_pkg::*;
#(
  parameter int unsigned OSR   = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_in,
  input  logic [1:0]        irq_sel,
  input  logic              rd_en,
  output logic [RXB_DW-1:0] rd_data,
  output logic              rd_ferr,
  input  logic              ovf_clr,
  output logic              data_avail,
  output logic              rx_idle,
  output logic              overrun,
  output logic              irq
);

  localparam int unsigned CHW = $bits(rxb_char_t);
  localparam int unsigned FW  = $clog2(DEPTH + 1);

  logic           rst_sn;
  logic           rx_s;
  logic           fr_done;
  rxb_char_t      fr_chr;
  rxb_char_t      head;
  logic [CHW-1:0] head_raw;
  logic [FW-1:0]  fill_lvl;
  logic [FW-1:0]  fill_nxt;
  logic           push_ok;
  logic           drop;

  rxb_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sn)
  );

  rxb_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (rx_in),
    .q     (rx_s)
  );

  rxb_deframer #(.OSR(OSR)) u_deframer (
    .clk   (clk),
    .rst_n (rst_sn),
    .tick  (baud_tick),
    .rx_s  (rx_s),
    .hold  (overrun),
    .done  (fr_done),
    .chr   (fr_chr),
    .idle  (rx_idle)
  );

  rxb_fifo #(.W(CHW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_sn),
    .push     (fr_done),
    .wdata    (fr_chr),
    .pop      (rd_en),
    .rdata    (head_raw),
    .fill     (fill_lvl),
    .fill_nxt (fill_nxt),
    .push_ok  (push_ok),
    .drop     (drop)
  );

  rxb_status #(.DEPTH(DEPTH)) u_status (
    .clk      (clk),
    .rst_n    (rst_sn),
    .push_ok  (push_ok),
    .drop     (drop),
    .fill_nxt (fill_nxt),
    .sel      (irq_sel),
    .clr      (ovf_clr),
    .overrun  (overrun),
    .irq      (irq)
  );

  assign head       = rxb_char_t'(head_raw);
  assign data_avail = (fill_lvl != '0);
  assign rd_data    = head.data;
  assign rd_ferr    = head.ferr & data_avail;

endmodule

// File: rtl/rx_char_buffer_chk.sv
module rx_char_buffer_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [1:0]    irq_sel,
  input logic          ovf_clr,
  input logic          data_avail,
  input logic          overrun,
  input logic          irq,
  input logic [FW-1:0] fill_lvl
);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovf_clr |=> overrun);

  // R9
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> fill_lvl == FW'(DEPTH));

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_3q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && irq_sel == 2'b10 && $stable(irq_sel) |-> fill_lvl == FW'((DEPTH * 3) / 4));

  // R6
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && irq_sel == 2'b11 && $stable(irq_sel) |-> fill_lvl == FW'(DEPTH));

  // R3
  avail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(rd_en));

endmodule

bind rx_char_buffer rx_char_buffer_chk #(.DEPTH(DEPTH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .rd_en      (rd_en),
  .irq_sel    (irq_sel),
  .ovf_clr    (ovf_clr),
  .data_avail (data_avail),
  .overrun    (overrun),
  .irq        (irq),
  .fill_lvl   (fill_lvl)
);

// File: tb/test_rx_char_buffer.sv
module test_rx_char_buffer;

  localparam int BIT = 16;
  localparam int NV  = 6;
  // bit 8 = stop bit level, bits 7:0 = data
  localparam logic [8:0] VEC [NV] = '{9'h155, 9'h100, 9'h1FF, 9'h03C, 9'h181, 9'h0A7};

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       rx_in;
  logic [1:0] irq_sel;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       rd_ferr;
  logic       ovf_clr;
  logic       data_avail;
  logic       rx_idle;
  logic       overrun;
  logic       irq;

  int n_vec;
  int n_miss;
  int irq_total;
  int snap;
  int lat;
  logic mid_idle;

  rx_char_buffer i_rx_char_buffer (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .rx_in      (rx_in),
    .irq_sel    (irq_sel),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_ferr    (rd_ferr),
    .ovf_clr    (ovf_clr),
    .data_avail (data_avail),
    .rx_idle    (rx_idle),
    .overrun    (overrun),
    .irq        (irq)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial irq_total = 0;
  always @(negedge clk) if (irq === 1'b1) irq_total = irq_total + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec = n_vec + 1;
    if (!ok) begin
      n_miss = n_miss + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int gbit);
    rx_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      if (i == gbit) begin
        repeat (8) @(negedge clk);
        rx_in = ~b[i];
        @(negedge clk);
        rx_in = b[i];
        repeat (7) @(negedge clk);
      end else if (i == 4) begin
        repeat (8) @(negedge clk);
        mid_idle = rx_idle;
        repeat (8) @(negedge clk);
      end else begin
        repeat (BIT) @(negedge clk);
      end
    end
    rx_in = stop;
    repeat (BIT) @(negedge clk);
    rx_in = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic pop1();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] exp, input string req);
    chk(data_avail === 1'b1, req, data_avail, 1);
    chk(rd_data === exp, req, rd_data, exp);
    pop1();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec = n_vec + 1;
    n_miss = n_miss + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_vec = 0;
    n_miss = 0;
    rst_n = 1'b0;
    baud_tick = 1'b1;
    rx_in = 1'b1;
    irq_sel = 2'b00;
    rd_en = 1'b0;
    ovf_clr = 1'b0;
    mid_idle = 1'b1;
    lat = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(data_avail === 1'b0, "R1", data_avail, 0);
    chk(rx_idle === 1'b1, "R1", rx_idle, 1);
    chk(overrun === 1'b0, "R1", overrun, 0);
    chk(irq === 1'b0, "R1", irq, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(data_avail === 1'b0 && rx_idle === 1'b1, "R1", {data_avail, rx_idle}, 2'b01);

    // R2 probe frame, also measures start-edge to write latency
    fork
      send_frame(8'hA5, 1'b1, -1);
      begin
        do begin
          @(negedge clk);
          lat = lat + 1;
        end while (data_avail !== 1'b1 && lat < 400);
      end
    join
    chk(lat > 100 && lat < 176, "R2", lat, 160);
    read_chk(8'hA5, "R2");

    // R2 R4 R7 R8 vector table
    for (int v = 0; v < NV; v++) begin
      irq_sel = {1'b0, 1'(v)};
      snap = irq_total;
      send_frame(VEC[v][7:0], VEC[v][8], -1);
      chk(mid_idle === 1'b0, "R7", mid_idle, 0);
      chk(rx_idle === 1'b1, "R7", rx_idle, 1);
      chk(irq_total - snap == 1, "R4", irq_total - snap, 1);
      chk(rd_ferr === ~VEC[v][8], "R8", rd_ferr, ~VEC[v][8]);
      read_chk(VEC[v][7:0], "R2");
      chk(data_avail === 1'b0, "R3", data_avail, 0);
    end

    // R5 R6 thresholds, then R9 overrun
    irq_sel = 2'b10;
    snap = irq_total;
    send_frame(8'h11, 1'b1, -1);
    chk(irq_total - snap == 0, "R5", irq_total - snap, 0);
    send_frame(8'h22, 1'b1, -1);
    chk(irq_total - snap == 0, "R5", irq_total - snap, 0);
    send_frame(8'h33, 1'b1, -1);
    chk(irq_total - snap == 1, "R5", irq_total - snap, 1);
    irq_sel = 2'b11;
    snap = irq_total;
    send_frame(8'h44, 1'b1, -1);
    chk(irq_total - snap == 1, "R6", irq_total - snap, 1);
    snap = irq_total;
    send_frame(8'h55, 1'b1, -1);
    chk(overrun === 1'b1, "R9", overrun, 1);
    chk(irq_total - snap == 0, "R9", irq_total - snap, 0);
    send_frame(8'h66, 1'b1, -1);
    chk(mid_idle === 1'b1, "R9", mid_idle, 1);
    repeat (40) @(negedge clk);
    chk(overrun === 1'b1, "R9", overrun, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(overrun === 1'b0, "R9", overrun, 0);
    read_chk(8'h11, "R3");
    read_chk(8'h22, "R3");
    read_chk(8'h33, "R3");
    read_chk(8'h44, "R3");
    chk(data_avail === 1'b0, "R9", data_avail, 0);

    // R12 pop on empty
    irq_sel = 2'b00;
    pop1();
    chk(data_avail === 1'b0, "R12", data_avail, 0);
    send_frame(8'h5A, 1'b1, -1);
    read_chk(8'h5A, "R12");
    chk(data_avail === 1'b0, "R12", data_avail, 0);

    // R11 write and pop in the same cycle on a full buffer
    send_frame(8'hC1, 1'b1, -1);
    send_frame(8'hC2, 1'b1, -1);
    send_frame(8'hC3, 1'b1, -1);
    send_frame(8'hC4, 1'b1, -1);
    fork
      send_frame(8'hC5, 1'b1, -1);
      begin
        repeat (lat - 1) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
      end
    join
    chk(overrun === 1'b0, "R11", overrun, 0);
    read_chk(8'hC2, "R11");
    read_chk(8'hC3, "R11");
    read_chk(8'hC4, "R11");
    read_chk(8'hC5, "R11");
    chk(data_avail === 1'b0, "R11", data_avail, 0);

    // R10 false start
    snap = irq_total;
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (200) @(negedge clk);
    chk(data_avail === 1'b0, "R10", data_avail, 0);
    chk(rx_idle === 1'b1, "R10", rx_idle, 1);
    chk(irq_total - snap == 0, "R10", irq_total - snap, 0);
    send_frame(8'h3E, 1'b1, -1);
    read_chk(8'h3E, "R10");

    // R13 single-tick glitch at mid-bit
    send_frame(8'h96, 1'b1, 2);
    read_chk(8'h96, "R13");

    // R8 error mark travels with its character
    send_frame(8'hE1, 1'b0, -1);
    send_frame(8'h1E, 1'b1, -1);
    chk(rd_ferr === 1'b1, "R8", rd_ferr, 1);
    read_chk(8'hE1, "R8");
    chk(rd_ferr === 1'b0, "R8", rd_ferr, 0);
    read_chk(8'h1E, "R8");

    finish_run();
  end

endmodule